// File: doc/BRIEF.md
# Pipelined RAM Port with Burst Address Counter

This block is one synchronous access port of a static memory. Every word is split into an upper and a lower byte lane. At each rising clock edge the port chooses the address for that cycle from one of four sources, listed here in order of precedence: a forced zero, the external address bus, the burst counter plus one, or the burst counter unchanged. The chosen address is used for the access in that same cycle, so no dead cycle is spent. It is also written back into the burst counter, so a single loaded address can be followed by a run of sequential or repeated accesses.

A cycle performs an access only when both chip selects agree. The direction line then picks read or write, and the two active-low lane enables gate the bytes. Read data passes through a memory output register and then an output register. A valid flag and a per-lane drive flag travel through the same pipeline, so a consumer knows which bytes hold data and which ones an output buffer would leave floating.

The depth is a parameter. `AW = 16` gives the full 65536-word array. The default is smaller so that elaboration stays light.

Top module: `bpram_port`

## Requirements
- R1: After reset the output valid flag, both lane drive flags and all data bits are 0, and the burst counter holds address 0, so a first access with all counter controls inactive goes to address 0.
- R2: With `clr_n_i` high and `ld_n_i` low at an edge, that cycle's access uses `addr_i`, and the counter takes that value. Holding `ld_n_i` low on every cycle gives fully random addressing.
- R3: With `clr_n_i` and `ld_n_i` high and `adv_n_i` low, the access goes to the counter value plus one, and the counter keeps that new value.
- R4: With `clr_n_i`, `ld_n_i` and `adv_n_i` all high, the counter holds, so repeated accesses hit the same word.
- R5: With `clr_n_i` low, that same cycle's access goes to address 0 and the counter becomes 0, whatever `ld_n_i`, `adv_n_i` and `addr_i` are.
- R6: When `ld_n_i` and `adv_n_i` are both low (and `clr_n_i` high), the load wins, so the access uses `addr_i` and not `addr_i + 1`.
- R7: Advancing from address 2^AW-1 wraps to address 0.
- R8: An access occurs only when `ce0_n_i` is 0 and `ce1_i` is 1. Any other combination writes nothing, and two edges later `rvalid_o` and `lane_oe_o` are 0.
- R9: A write (`rw_i` = 0) changes lane 0, bits [BW-1:0], only if `lb_n_i` is 0. It changes lane 1, bits [2*BW-1:BW], only if `ub_n_i` is 0. A disabled lane keeps its old contents.
- R10: For an enabled read (`rw_i` = 1) sampled at edge k, `rvalid_o` is 1 and the word is on `dout_o` from edge k+1, and not before. `rvalid_o` is 1 only for cycles that were enabled reads.
- R11: On a read, `lane_oe_o[i]` is 1 only for lanes whose enable was low. Lanes whose drive flag is 0 show all-zero data bits.
- R12: The counter controls act whether or not the chip selects enable an access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr_i | input | AW | External address |
| din_i | input | 2*BW | Write data, lane 1 in the upper half |
| rw_i | input | 1 | 1 = read, 0 = write |
| ce0_n_i | input | 1 | Chip select, active low |
| ce1_i | input | 1 | Chip select, active high |
| ub_n_i | input | 1 | Lane 1 (upper byte) enable, active low |
| lb_n_i | input | 1 | Lane 0 (lower byte) enable, active low |
| ld_n_i | input | 1 | Load external address, active low |
| adv_n_i | input | 1 | Advance counter, active low |
| clr_n_i | input | 1 | Force address 0, active low |
| dout_o | output | 2*BW | Registered read data |
| lane_oe_o | output | 2 | Per-lane drive flag; 0 means high impedance |
| rvalid_o | output | 1 | Registered read valid |

## Verification
The assertions assume that reset is asserted before the first edge and that every control and address input carries a defined 0 or 1 at each rising edge after reset. The counter and latency properties compare the current cycle against earlier cycles, so they would be meaningless on unknown values. The bench drives all inputs at every falling edge through a single stepping task, and it fills the array before reading any word, so neither the design nor the bench reference model ever meets an undefined control or an unwritten location.

// File: rtl/bpram_pkg.sv
package bpram_pkg;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_ADV  = 2'd1,
    SRC_LOAD = 2'd2,
    SRC_CLR  = 2'd3
  } addr_src_e;

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bpram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr_i,
  input  logic          ld_n_i,
  input  logic          adv_n_i,
  input  logic          clr_n_i,
  output logic [AW-1:0] acc_addr_o
);

  addr_src_e     src;
  logic [AW-1:0] cnt_q;
  logic [AW-1:0] cnt_d;
  logic          cnt_en;

  // source priority: clear, load, advance, hold
  always_comb begin
    if (!clr_n_i)      src = SRC_CLR;
    else if (!ld_n_i)  src = SRC_LOAD;
    else if (!adv_n_i) src = SRC_ADV;
    else               src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_CLR:  cnt_d = '0;
      SRC_LOAD: cnt_d = ext_addr_i;
      SRC_ADV:  cnt_d = cnt_q + 1'b1;
      default:  cnt_d = cnt_q;
    endcase
    cnt_en = (src != SRC_HOLD);
  end

  assign acc_addr_o = cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/lane_mem.sv
module lane_mem #(
  parameter int AW = 10,
  parameter int BW = 9
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [BW-1:0] mem [DEPTH];
  logic [BW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[addr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (re_i) begin
      rdata_q <= mem[addr_i];
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/rd_pipe.sv
module rd_pipe #(
  parameter int LANES = 2,
  parameter int BW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_req_i,
  input  logic [LANES-1:0]    lane_re_i,
  input  logic [LANES*BW-1:0] lane_rdata_i,
  output logic [LANES*BW-1:0] dout_o,
  output logic [LANES-1:0]    lane_oe_o,
  output logic                rvalid_o
);

  localparam int DW = LANES * BW;

  logic             s1_valid_q;
  logic [LANES-1:0] s1_oe_q;
  logic             out_valid_q;
  logic [LANES-1:0] out_oe_q;
  logic [DW-1:0]    out_data_q;
  logic [DW-1:0]    out_data_d;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_gate
      assign out_data_d[g*BW +: BW] = s1_oe_q[g] ? lane_rdata_i[g*BW +: BW] : '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q  <= 1'b0;
      s1_oe_q     <= '0;
      out_valid_q <= 1'b0;
      out_oe_q    <= '0;
      out_data_q  <= '0;
    end else begin
      s1_valid_q  <= rd_req_i;
      s1_oe_q     <= lane_re_i;
      out_valid_q <= s1_valid_q;
      out_oe_q    <= s1_oe_q;
      out_data_q  <= out_data_d;
    end
  end

  assign dout_o    = out_data_q;
  assign lane_oe_o = out_oe_q;
  assign rvalid_o  = out_valid_q;

endmodule

// File: rtl/bpram_port.sv
module bpram_port #(
  parameter int AW = 10,
  parameter int BW = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr_i,
  input  logic [2*BW-1:0] din_i,
  input  logic            rw_i,
  input  logic            ce0_n_i,
  input  logic            ce1_i,
  input  logic            ub_n_i,
  input  logic            lb_n_i,
  input  logic            ld_n_i,
  input  logic            adv_n_i,
  input  logic            clr_n_i,
  output logic [2*BW-1:0] dout_o,
  output logic [1:0]      lane_oe_o,
  output logic            rvalid_o
);

  localparam int LANES = 2;
  localparam int DW    = LANES * BW;

  logic [AW-1:0]    acc_addr;
  logic             acc_en;
  logic             wr_req;
  logic             rd_req;
  logic [LANES-1:0] lane_en_n;
  logic [LANES-1:0] lane_we;
  logic [LANES-1:0] lane_re;
  logic [DW-1:0]    lane_rdata;

  burst_addr_gen #(.AW(AW)) i_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_addr_i (addr_i),
    .ld_n_i     (ld_n_i),
    .adv_n_i    (adv_n_i),
    .clr_n_i    (clr_n_i),
    .acc_addr_o (acc_addr)
  );

  assign lane_en_n = {ub_n_i, lb_n_i};
  assign acc_en    = !ce0_n_i && ce1_i;
  assign wr_req    = acc_en && !rw_i;
  assign rd_req    = acc_en && rw_i;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_we[g] = wr_req && !lane_en_n[g];
      assign lane_re[g] = rd_req && !lane_en_n[g];

      lane_mem #(.AW(AW), .BW(BW)) i_mem (
        .clk     (clk),
        .we_i    (lane_we[g]),
        .re_i    (lane_re[g]),
        .addr_i  (acc_addr),
        .wdata_i (din_i[g*BW +: BW]),
        .rdata_o (lane_rdata[g*BW +: BW])
      );
    end
  endgenerate

  rd_pipe #(.LANES(LANES), .BW(BW)) i_pipe (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req_i     (rd_req),
    .lane_re_i    (lane_re),
    .lane_rdata_i (lane_rdata),
    .dout_o       (dout_o),
    .lane_oe_o    (lane_oe_o),
    .rvalid_o     (rvalid_o)
  );

endmodule

// File: rtl/bpram_port_chk.sv
module bpram_port_chk #(
  parameter int AW = 10,
  parameter int BW = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   addr_i,
  input logic            rw_i,
  input logic            ce0_n_i,
  input logic            ce1_i,
  input logic            ld_n_i,
  input logic            adv_n_i,
  input logic            clr_n_i,
  input logic [AW-1:0]   acc_addr,
  input logic [2*BW-1:0] dout_o,
  input logic [1:0]      lane_oe_o,
  input logic            rvalid_o
);

  logic [1:0] cyc_q;
  logic       rd_req;

  assign rd_req = !ce0_n_i && ce1_i && rw_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
    end else if (cyc_q != 2'd3) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n_i |-> acc_addr == '0);

  a_r2_load_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n_i && !ld_n_i) |-> acc_addr == addr_i);

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q != 2'd0 && clr_n_i && ld_n_i && !adv_n_i)
      |-> acc_addr == AW'($past(acc_addr) + 1'b1));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q != 2'd0 && clr_n_i && ld_n_i && adv_n_i)
      |-> acc_addr == $past(acc_addr));

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2) |-> rvalid_o == $past(rd_req, 2));

  a_r11_oe_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe_o != 2'b00) |-> rvalid_o);

  generate
    for (genvar g = 0; g < 2; g++) begin : g_zero
      a_r11_idle_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_oe_o[g] |-> dout_o[g*BW +: BW] == '0);
    end
  endgenerate

endmodule

bind bpram_port bpram_port_chk #(.AW(AW), .BW(BW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_i    (addr_i),
  .rw_i      (rw_i),
  .ce0_n_i   (ce0_n_i),
  .ce1_i     (ce1_i),
  .ld_n_i    (ld_n_i),
  .adv_n_i   (adv_n_i),
  .clr_n_i   (clr_n_i),
  .acc_addr  (acc_addr),
  .dout_o    (dout_o),
  .lane_oe_o (lane_oe_o),
  .rvalid_o  (rvalid_o)
);

// File: tb/test_bpram_port.sv
module test_bpram_port;

  localparam int CLK_P = 10;
  localparam int AW    = 10;
  localparam int BW    = 9;
  localparam int DW    = 2 * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] din_i;
  logic          rw_i, ce0_n_i, ce1_i, ub_n_i, lb_n_i, ld_n_i, adv_n_i, clr_n_i;
  logic [DW-1:0] dout_o;
  logic [1:0]    lane_oe_o;
  logic          rvalid_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [DW-1:0] mdl_mem [DEPTH];
  logic [AW-1:0] m_cnt = '0;
  logic          stg_v = 1'b0;
  logic [1:0]    stg_oe = 2'b00;
  logic [DW-1:0] stg_d = '0;
  string         stg_tag = "R10";

  always #(CLK_P/2) clk = ~clk;

  bpram_port #(.AW(AW), .BW(BW)) i_bpram_port (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .din_i(din_i), .rw_i(rw_i),
    .ce0_n_i(ce0_n_i), .ce1_i(ce1_i), .ub_n_i(ub_n_i), .lb_n_i(lb_n_i),
    .ld_n_i(ld_n_i), .adv_n_i(adv_n_i), .clr_n_i(clr_n_i),
    .dout_o(dout_o), .lane_oe_o(lane_oe_o), .rvalid_o(rvalid_o)
  );

  task automatic check(input string tag, input logic ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  // one clock cycle: drive, model, then compare outputs produced at this edge
  task automatic step(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic rw, input logic c0n, input logic c1,
                      input logic ubn, input logic lbn,
                      input logic ldn, input logic advn, input logic clrn);
    logic [AW-1:0] ma;
    logic          en, nv;
    logic [1:0]    noe;
    logic [DW-1:0] nd;
    @(negedge clk);
    addr_i = a; din_i = d; rw_i = rw; ce0_n_i = c0n; ce1_i = c1;
    ub_n_i = ubn; lb_n_i = lbn; ld_n_i = ldn; adv_n_i = advn; clr_n_i = clrn;
    if (!clrn)      ma = '0;
    else if (!ldn)  ma = a;
    else if (!advn) ma = m_cnt + 1'b1;
    else            ma = m_cnt;
    m_cnt = ma;
    en  = !c0n && c1;
    nv  = en && rw;
    noe = {nv && !ubn, nv && !lbn};
    nd  = {noe[1] ? mdl_mem[ma][DW-1:BW] : {BW{1'b0}}, noe[0] ? mdl_mem[ma][BW-1:0] : {BW{1'b0}}};
    if (en && !rw) begin
      if (!lbn) mdl_mem[ma][BW-1:0]  = d[BW-1:0];
      if (!ubn) mdl_mem[ma][DW-1:BW] = d[DW-1:BW];
    end
    @(posedge clk);
    #(CLK_P/4);
    check(stg_tag, rvalid_o === stg_v && lane_oe_o === stg_oe && dout_o === stg_d,
          $sformatf("valid=%b oe=%b data=%h expected valid=%b oe=%b data=%h",
                    rvalid_o, lane_oe_o, dout_o, stg_v, stg_oe, stg_d));
    stg_v = nv; stg_oe = noe; stg_d = nd; stg_tag = tag;
  endtask

  task automatic idle(input string tag);
    step(tag, '0, '0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic rd_ld(input string tag, input logic [AW-1:0] a);
    step(tag, a, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 1237 + 91);
  endfunction

  task automatic t_reset();
    check("R1", rvalid_o === 1'b0 && lane_oe_o === 2'b00 && dout_o === '0,
          $sformatf("after reset valid=%b oe=%b data=%h expected 0 0 0", rvalid_o, lane_oe_o, dout_o));
    // hold write right after reset lands on address 0
    step("R1", 10'd77, 18'h2AAAA, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    rd_ld("R1", '0);
    idle("R1");
    idle("R1");
    check("R1", mdl_mem[0] === 18'h2AAAA, "model address 0 not written");
  endtask

  task automatic t_fill();
    step("R5", 10'd500, pat(0), 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 1; i < DEPTH; i++)
      step("R3", 10'd3, pat(i), 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_random_load();
    rd_ld("R2", 10'd513); rd_ld("R2", 10'd7); rd_ld("R2", 10'd1000);
    rd_ld("R2", 10'd0); rd_ld("R2", 10'd255); idle("R2"); idle("R2");
  endtask

  task automatic t_burst();
    rd_ld("R3", 10'd100);
    for (int i = 0; i < 6; i++)
      step("R3", 10'd9, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    idle("R3"); idle("R3");
  endtask

  task automatic t_hold();
    step("R4", 10'd200, 18'h11111, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R4", 10'd5, 18'h22222, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    step("R4", 10'd6, 18'h33333, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    step("R4", 10'd6, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    rd_ld("R4", 10'd201);
    idle("R4"); idle("R4");
    check("R4", mdl_mem[200] === 18'h33333, "model hold target");
  endtask

  task automatic t_clear();
    step("R5", 10'd55, 18'h0ABCD, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rd_ld("R5", 10'd55);
    rd_ld("R5", 10'd0);
    step("R5", 10'd3, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    idle("R5"); idle("R5");
  endtask

  task automatic t_prio();
    step("R6", 10'd300, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R6", 10'd300, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    idle("R6"); idle("R6");
  endtask

  task automatic t_wrap();
    rd_ld("R7", AW'(DEPTH - 1));
    step("R7", 10'd44, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    step("R7", 10'd44, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    idle("R7"); idle("R7");
  endtask

  task automatic t_chip_enable();
    step("R8", 10'd400, 18'h3FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R8", 10'd401, 18'h3FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R8", 10'd400, '0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R8", 10'd401, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    rd_ld("R8", 10'd400); rd_ld("R8", 10'd401);
    idle("R8"); idle("R8");
    check("R8", mdl_mem[400] === pat(400), "model changed by disabled write");
  endtask

  task automatic t_lanes();
    step("R9", 10'd600, 18'h1FFFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R9", 10'd601, 18'h3FE00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    step("R9", 10'd602, 18'h3FFFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    rd_ld("R9", 10'd600); rd_ld("R9", 10'd601); rd_ld("R9", 10'd602);
    step("R11", 10'd600, '0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R11", 10'd601, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    step("R11", 10'd602, '0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    idle("R11"); idle("R11");
  endtask

  task automatic t_latency();
    rd_ld("R10", 10'd123);
    check("R10", rvalid_o === 1'b0, $sformatf("valid=%b one edge after read, expected 0", rvalid_o));
    idle("R10");
    check("R10", rvalid_o === 1'b1 && dout_o === pat(123),
          $sformatf("valid=%b data=%h expected 1 %h", rvalid_o, dout_o, pat(123)));
    idle("R10");
  endtask

  task automatic t_counter_ce_off();
    step("R12", 10'd700, '0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R12", 10'd3, '0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    step("R12", 10'd3, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    idle("R12"); idle("R12");
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    addr_i = '0; din_i = '0; rw_i = 1'b1; ce0_n_i = 1'b1; ce1_i = 1'b0;
    ub_n_i = 1'b1; lb_n_i = 1'b1; ld_n_i = 1'b1; adv_n_i = 1'b1; clr_n_i = 1'b1;
    for (int i = 0; i < DEPTH; i++) mdl_mem[i] = 'x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #(CLK_P/4);
    t_reset();
    t_fill();
    t_random_load();
    t_burst();
    t_hold();
    t_clear();
    t_prio();
    t_wrap();
    t_chip_enable();
    t_lanes();
    t_latency();
    t_counter_ce_off();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule